// File: doc/BRIEF.md
# Subarray Idle-Timeout Power-Gate Controller

This block decides whether the peripheral circuitry of one memory subarray is powered or gated. Each cycle it looks at the access strobes aimed at its subarray. It counts the cycles in a row that carry no access, and when that count reaches a programmable limit it gates the subarray. A later read or array write brings the subarray out of sleep through a wake sequence lasting a fixed number of cycles. During that sequence the requester is held off by a low `ready`.

Writes that a separate write buffer absorbs come in on their own strobe. They neither wake the subarray nor restart its idle count, so a run of buffered writes does not keep the subarray powered. Two free-running counters record how many cycles the subarray spends asleep and how many it spends fully active, so the sleep rate can be computed outside the block. One controller is placed per subarray, and the controllers run independently of each other.

Top module: `subarray_pg_ctrl`

## Requirements
- R1: After reset the controller is active: `pwr_en`=1, `ready`=1, `is_active`=1, `is_sleep`=0, and both statistics counters read 0.
- R2: In the active state, T consecutive cycles with neither `rd_req` nor `wr_req` high put the controller to sleep starting with the next cycle: `pwr_en`=0, `ready`=0, `is_sleep`=1. T is `cfg_timeout`.
- R3: A cycle in the active state that has `rd_req` or `wr_req` high restarts the idle count from zero, and the controller stays active.
- R4: When `rd_req` or `wr_req` is seen in the sleep state, the controller enters a wake state for exactly WAKE_CYC cycles and then becomes active. In the wake state `pwr_en`=1 and `ready`=0. `ready` first reads 1 exactly WAKE_CYC+1 cycles after the cycle that carried the waking request.
- R5: `wr_absorbed` has no effect. It does not wake a sleeping subarray, and it does not restart the idle count in the active state.
- R6: In the sleep state, with no `rd_req` and no `wr_req`, the controller stays asleep.
- R7: `sleep_cycles` increments by one for every clock cycle spent in the sleep state. `active_cycles` increments by one for every clock cycle spent in the active state. Neither counter changes during the wake state.
- R8: A `cfg_timeout` of 0 selects the default limit of 1024 idle cycles. With that setting the controller is still active after 1023 idle cycles and asleep after 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Demand read strobe for this subarray |
| wr_req | input | 1 | Array write strobe for this subarray |
| wr_absorbed | input | 1 | Write taken by the write buffer (no array access) |
| cfg_timeout | input | CNT_W | Idle limit in cycles; 0 selects 1024 |
| pwr_en | output | 1 | Peripheral power enable |
| ready | output | 1 | Access can be served this cycle |
| is_sleep | output | 1 | Controller is in the sleep state |
| is_active | output | 1 | Controller is in the active state |
| sleep_cycles | output | STAT_W | Cycles spent asleep |
| active_cycles | output | STAT_W | Cycles spent active |

## Verification
The hardest cases to reach from the ports are an access that lands in the very last idle cycle before the limit, and a request that arrives in the first cycle of sleep. Both depend on the exact cycle at which the timeout expires. The stimulus runs many short segments with small random limits and random request densities, which makes expiry edges occur often. A reference model in the bench tracks the state every cycle. Directed sequences cover the 1024-cycle default limit, buffered writes during sleep and during idle counting, and a held request that is measured through the whole wake penalty.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_ACTIVE = 2'd0,
    PG_SLEEP  = 2'd1,
    PG_WAKING = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_idle_timer.sv
module pg_idle_timer #(
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg_limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   cnt_inc;

  // zero in the configuration selects the built-in limit
  function automatic logic [CNT_W-1:0] pick_limit(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(DEF_LIMIT) : c;
  endfunction

  assign lim     = pick_limit(cfg_limit);
  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  assign expire  = tick && (cnt_inc >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || expire)  cnt <= '0;
    else if (tick)           cnt <= cnt_inc[CNT_W-1:0];
  end

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pg_wake_timer.sv
module pg_wake_timer #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int WW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);

  logic [WW-1:0] cnt;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= WW'(WAKE_CYC - 1);
    else if (run && cnt != '0)     cnt <= cnt - WW'(1);
  end

  // R4
  wake_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && !load) |=> (cnt == $past(cnt) - WW'(1)));
endmodule

// File: rtl/pg_stat_counter.sv
module pg_stat_counter #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [STAT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt + STAT_W'(1);
  end

  // R7
  stat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt == $past(cnt) + STAT_W'(1)));
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/subarray_pg_ctrl.sv
module subarray_pg_ctrl
  import pg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_TIMEOUT = 1024,
  parameter int WAKE_CYC    = 4,
  parameter int STAT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              wr_absorbed,
  input  logic [CNT_W-1:0]  cfg_timeout,
  output logic              pwr_en,
  output logic              ready,
  output logic              is_sleep,
  output logic              is_active,
  output logic [STAT_W-1:0] sleep_cycles,
  output logic [STAT_W-1:0] active_cycles
);
  localparam int NSTAT = 2;

  pg_state_e st, st_nx;
  logic access, idle_tick, idle_clr, idle_expire;
  logic wake_load, wake_run, wake_done;
  logic [NSTAT-1:0]  stat_en;
  logic [STAT_W-1:0] stat_val [NSTAT];

  assign access    = rd_req | wr_req;
  assign idle_tick = (st == PG_ACTIVE) && !access;
  assign idle_clr  = (st != PG_ACTIVE) || access;
  assign wake_load = (st == PG_SLEEP) && access;
  assign wake_run  = (st == PG_WAKING);

  pg_idle_timer #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_TIMEOUT)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(idle_tick),
    .cfg_limit(cfg_timeout), .expire(idle_expire));

  pg_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .load(wake_load), .run(wake_run),
    .done(wake_done));

  always_comb begin
    st_nx = st;
    unique case (st)
      PG_ACTIVE: if (idle_expire) st_nx = PG_SLEEP;
      PG_SLEEP:  if (access)      st_nx = PG_WAKING;
      PG_WAKING: if (wake_done)   st_nx = PG_ACTIVE;
      default:                    st_nx = PG_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= PG_ACTIVE;
    else        st <= st_nx;
  end

  assign pwr_en    = (st != PG_SLEEP);
  assign ready     = (st == PG_ACTIVE);
  assign is_sleep  = (st == PG_SLEEP);
  assign is_active = (st == PG_ACTIVE);

  assign stat_en[0] = is_sleep;
  assign stat_en[1] = is_active;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    pg_stat_counter #(.STAT_W(STAT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(stat_en[g]), .cnt(stat_val[g]));
  end

  assign sleep_cycles  = stat_val[0];
  assign active_cycles = stat_val[1];

  // R2
  expire_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_expire |=> is_sleep);
  // R3
  access_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && access) |=> is_active);
  // R4
  no_skip_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sleep |=> !is_active);
  // R4
  waking_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> !ready);
  // R5
  absorbed_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sleep && wr_absorbed && !access) |=> is_sleep);
  // R6
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sleep && !access) |=> is_sleep);
endmodule

// File: tb/sim_subarray_pg_ctrl.sv
module sim_subarray_pg_ctrl;
  localparam int CNT_W = 16, WAKE = 4, STAT_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, wr_absorbed = 0;
  logic [CNT_W-1:0] cfg_timeout = '0;
  logic pwr_en, ready, is_sleep, is_active;
  logic [STAT_W-1:0] sleep_cycles, active_cycles;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // model: 0 active, 1 sleep, 2 waking
  int m_st = 0, m_idle = 0, m_wleft = 0;
  longint m_slp = 0, m_act = 0;

  always #4 clk = ~clk;

  subarray_pg_ctrl #(.CNT_W(CNT_W), .WAKE_CYC(WAKE), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .wr_absorbed(wr_absorbed), .cfg_timeout(cfg_timeout), .pwr_en(pwr_en),
    .ready(ready), .is_sleep(is_sleep), .is_active(is_active),
    .sleep_cycles(sleep_cycles), .active_cycles(active_cycles));

  function automatic int limit_of(input logic [CNT_W-1:0] c);
    return (c == 0) ? 1024 : int'(c);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_idle = 0; m_wleft = 0; m_slp = 0; m_act = 0;
    end else if (m_st == 0) begin
      m_act++;
      if (rd_req || wr_req) m_idle = 0;
      else begin
        m_idle++;
        if (m_idle >= limit_of(cfg_timeout)) begin m_st = 1; m_idle = 0; end
      end
    end else if (m_st == 1) begin
      m_slp++;
      if (rd_req || wr_req) begin m_st = 2; m_wleft = WAKE; end
    end else begin
      m_wleft--;
      if (m_wleft == 0) begin m_st = 0; m_idle = 0; end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 pwr_en", longint'(pwr_en), longint'(m_st != 1));
    chk("R4 ready", longint'(ready), longint'(m_st == 0));
    chk("R6 is_sleep", longint'(is_sleep), longint'(m_st == 1));
    chk("R3 is_active", longint'(is_active), longint'(m_st == 0));
    chk("R7 sleep_cycles", longint'(sleep_cycles), m_slp);
    chk("R7 active_cycles", longint'(active_cycles), m_act);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle_drive();
    rd_req = 0; wr_req = 0; wr_absorbed = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pwr_en", longint'(pwr_en), 1);
    chk("R1 ready", longint'(ready), 1);
    chk("R1 is_active", longint'(is_active), 1);
    chk("R1 is_sleep", longint'(is_sleep), 0);
    chk("R1 sleep_cycles", longint'(sleep_cycles), 0);
    chk("R1 active_cycles", longint'(active_cycles), 0);

    // R8 default limit of 1024
    cfg_timeout = '0; rd_req = 1; step(); rd_req = 0;
    repeat (1023) step();
    chk("R8 active after 1023 idle", longint'(is_active), 1);
    step();
    chk("R8 sleep after 1024 idle", longint'(is_sleep), 1);

    // R5 absorbed writes during sleep and during idle counting
    wr_absorbed = 1;
    repeat (10) step();
    chk("R5 still asleep", longint'(is_sleep), 1);
    chk("R5 power off", longint'(pwr_en), 0);

    // R4 held read through the wake penalty
    wr_absorbed = 0; rd_req = 1;
    step();
    chk("R4 waking powered", longint'(pwr_en), 1);
    chk("R4 waking stalls", longint'(ready), 0);
    repeat (WAKE - 1) step();
    chk("R4 still stalled", longint'(ready), 0);
    step();
    chk("R4 ready after wake", longint'(ready), 1);

    cfg_timeout = 16'd5; step(); rd_req = 0; wr_absorbed = 1;
    repeat (4) step();
    chk("R5 absorbed does not reset idle", longint'(is_active), 1);
    step();
    chk("R5 sleeps despite absorbed", longint'(is_sleep), 1);

    // R2 / R3 random segments
    void'($urandom(32'd1357));
    for (int s = 0; s < 60; s++) begin
      int dens;
      cfg_timeout = CNT_W'(1 + $urandom_range(0, 11));
      dens = $urandom_range(2, 40);
      for (int k = 0; k < 200; k++) begin
        rd_req      = ($urandom_range(0, 99) < dens / 2);
        wr_req      = ($urandom_range(0, 99) < dens / 3);
        wr_absorbed = ($urandom_range(0, 99) < 30);
        step();
      end
      idle_drive();
    end

    // R3 access at the last idle cycle before expiry
    cfg_timeout = 16'd3; rd_req = 1;
    repeat (WAKE + 2) step();
    rd_req = 0; step(); step();
    wr_req = 1; step(); wr_req = 0;
    step(); step();
    chk("R3 restart kept active", longint'(is_active), 1);
    step();
    chk("R2 sleep after restart", longint'(is_sleep), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule